// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a system-monitor watchdog for a small microcontroller. The oscillator clock first passes through a fixed divide-by-twelve stage. A prescaler chosen by software then divides it further by a power of two from 2 to 256. The result clocks a wide timeout counter. When that counter rolls over while the watchdog is enabled, the block emits a one-cycle internal reset request. Software keeps the system alive by setting a self-clearing clear bit before the timeout expires. The clear restarts both the timeout counter and the prescaler.

An idle indication from the power manager can freeze the whole counting chain. A separate control bit lets the watchdog keep counting through idle. The block has no data stream, so there is no valid/ready interface. All pins are plain control and status signals. A write strobe with its data byte updates the control register in one cycle, and the register is always visible on the readback port. The request output is intended to feed the chip's reset generator. That generator in turn drives this block's reset, so a watchdog-caused reset leaves the watchdog disabled.

Top module: `wdog_prescaled`

## Requirements
- R1: While `rst_n` is low and just after it is released, `ctl_rdata_o` reads 8'h00 and `wdt_rst_req_o` is 0. This means the watchdog is disabled, the count-in-idle bit is 0, and the counters are zero.
- R2: The control byte has this layout: bit 7 enables the watchdog, bit 6 is the clear bit, bit 5 allows counting in idle, bits 4:3 are unused, and bits 2:0 select the prescaler. A write on `ctl_wr_i` loads it on the next rising edge, and the unused bits always read 0.
- R3: Prescaler select codes map to dividers as follows: 3'b000 gives 2, 3'b010 gives 4, 3'b001 gives 8, 3'b011 gives 16, 3'b100 gives 32, 3'b101 gives 64, 3'b110 gives 128 and 3'b111 gives 256. Suppose the register is written with enable set at edge E while the counters are zero. Then `wdt_rst_req_o` goes high just after edge E + BASE_DIV × divider × 2^CNT_W and not earlier.
- R4: The reset request is high for exactly one cycle. The timeout counter wraps to zero at the overflow, so with no clear the next request follows one full period later.
- R5: If a write sets the clear bit, that bit reads 1 for exactly one cycle and then returns to 0 by itself. The edge that drops it also zeroes the timeout counter and the prescaler, so the next request comes one full period after that edge.
- R6: While `idle_i` is 1 and the count-in-idle bit is 0, the counting chain holds its value. With the count-in-idle bit set, idle has no effect on the timeout.
- R7: While the enable bit is 0, the counter and prescaler are held at zero and no request is emitted. Enabling again therefore starts a full timeout period.
- R8: Asserting `rst_n` in the middle of a count returns the block to the R1 state. After that, a new enable starts a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| idle_i | input | 1 | High while the processor is in idle mode |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register readback |
| wdt_rst_req_o | output | 1 | One-cycle internal reset request on timeout |

## Verification
On every cycle, the bound checker watches several behaviours. It checks that the request is a single pulse and that the clear bit drops after one cycle and zeroes the timeout counter. It checks that a disabled watchdog holds the counter at zero, that the counter freezes during idle unless counting in idle is allowed, and that the counter only steps by one or restarts. Only the bench scenarios can show the exact timeout length for each prescaler code. The same applies to how a clear, an idle window or a mid-count reset moves the next request, and to the readback layout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PSEL_W = 3;
  localparam int PRE_W  = 1 << PSEL_W;   // widest divider is 2^PRE_W
  localparam int EXP_W  = PSEL_W + 1;

  // control byte bit positions
  localparam int BIT_EN   = 7;
  localparam int BIT_CLR  = 6;
  localparam int BIT_WIDL = 5;

  // divider exponent: divider = 2 ** psel_exp(code)
  function automatic logic [EXP_W-1:0] psel_exp(input logic [PSEL_W-1:0] code);
    logic [EXP_W-1:0] e;
    case (code)
      3'b000:  e = EXP_W'(1);
      3'b010:  e = EXP_W'(2);
      3'b001:  e = EXP_W'(3);
      3'b011:  e = EXP_W'(4);
      default: e = EXP_W'(code) + EXP_W'(1);
    endcase
    return e;
  endfunction
endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic              en_o,
  output logic              clr_o,
  output logic              widl_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic [7:0]        rdata_o
);
  logic              en_q, clr_q, widl_q;
  logic [PSEL_W-1:0] psel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      clr_q  <= 1'b0;
      widl_q <= 1'b0;
      psel_q <= '0;
    end else if (wr_i) begin
      en_q   <= wdata_i[BIT_EN];
      clr_q  <= wdata_i[BIT_CLR];
      widl_q <= wdata_i[BIT_WIDL];
      psel_q <= wdata_i[PSEL_W-1:0];
    end else begin
      clr_q  <= 1'b0;              // self-clearing after one cycle
    end
  end

  assign en_o   = en_q;
  assign clr_o  = clr_q;
  assign widl_o = widl_q;
  assign psel_o = psel_q;
  assign rdata_o = {en_q, clr_q, widl_q, {(5-PSEL_W){1'b0}}, psel_q};
endmodule

// File: rtl/wdog_tick_chain.sv
module wdog_tick_chain
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              zero_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  localparam int BASE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;

  logic [BASE_W-1:0] base_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  sel_mask;
  logic [EXP_W-1:0]  sel_exp;
  logic              base_wrap, pre_full;

  assign sel_exp   = psel_exp(psel_i);
  assign base_wrap = (base_q == BASE_W'(BASE_DIV - 1));

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign sel_mask[i] = (EXP_W'(i) < sel_exp);
  end

  assign pre_full = &(pre_q | ~sel_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (zero_i) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (run_i) begin
      base_q <= base_wrap ? '0 : base_q + 1'b1;
      if (base_wrap) pre_q <= pre_q + 1'b1;
    end
  end

  assign tick_o = run_i & base_wrap & pre_full;
endmodule

// File: rtl/wdog_timeout_cnt.sv
module wdog_timeout_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             ovf;

  assign ovf = tick_i & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= ovf;
      if (zero_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;   // wraps to zero on overflow
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 12,
  parameter int CNT_W    = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  output logic       wdt_rst_req_o
);
  logic              en, clr, widl;
  logic [PSEL_W-1:0] psel;
  logic              run, zero, tick;
  logic [CNT_W-1:0]  cnt_q;

  wdog_ctl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ctl_wr_i),
    .wdata_i(ctl_wdata_i),
    .en_o   (en),
    .clr_o  (clr),
    .widl_o (widl),
    .psel_o (psel),
    .rdata_o(ctl_rdata_o)
  );

  assign zero = ~en | clr;
  assign run  = en & ~clr & (~idle_i | widl);

  wdog_tick_chain #(.BASE_DIV(BASE_DIV)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run),
    .zero_i(zero),
    .psel_i(psel),
    .tick_o(tick)
  );

  wdog_timeout_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .zero_i(zero),
    .tick_i(tick),
    .cnt_o (cnt_q),
    .req_o (wdt_rst_req_o)
  );
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_i,
  input logic [7:0]       rdata,
  input logic             req,
  input logic [CNT_W-1:0] cnt
);
  // R4: request lasts one cycle
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  // R5: clear bit drops by itself after one cycle
  p_clr_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6] |=> !rdata[6]);

  // R5: a pending clear zeroes the timeout counter
  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6] |=> (cnt == '0));

  // R7: disabled watchdog holds zero and never requests
  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[7] |=> (cnt == '0 && !req));

  // R6: idle freezes the counter unless counting in idle is allowed
  p_idle_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[7] && !rdata[6] && idle_i && !rdata[5]) |=> $stable(cnt));

  // R3: the counter only advances by one or restarts
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7] |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

  // R2: unused bits read zero
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[4:3] == 2'b00);
endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .idle_i(idle_i),
  .rdata (ctl_rdata_o),
  .req   (wdt_rst_req_o),
  .cnt   (cnt_q)
);

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;
  localparam int PERIOD = 10;
  localparam int BDIV   = 12;
  localparam int CW     = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       req;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #(PERIOD/2) clk = ~clk;

  wdog_prescaled #(.BASE_DIV(BDIV), .CNT_W(CW)) u_wdog_prescaled (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_i       (idle),
    .ctl_wr_i     (wr),
    .ctl_wdata_i  (wdata),
    .ctl_rdata_o  (rdata),
    .wdt_rst_req_o(req)
  );

  always @(negedge clk) if (req) pulses++;

  function automatic int div_of(input logic [2:0] code);
    case (code)
      3'b000: return 2;
      3'b010: return 4;
      3'b001: return 8;
      3'b011: return 16;
      3'b100: return 32;
      3'b101: return 64;
      3'b110: return 128;
      default: return 256;
    endcase
  endfunction

  function automatic int period_of(input logic [2:0] code);
    return BDIV * div_of(code) * (1 << CW);
  endfunction

  task automatic check(input string req_id, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req_id, actual, expected, $time);
    end
  endtask

  // leaves the bench at the negedge after the write edge
  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk);
    wr = 1'b1; wdata = v;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // current position: just after edge X; expects the pulse just after edge X+ofs
  task automatic expect_req_at(input string req_id, input int ofs);
    step(ofs - 1);
    check(req_id, req, 0);
    step(1);
    check(req_id, req, 1);
    step(1);
    check(req_id, req, 0);
  endtask

  task automatic t_reset;        // R1
    check("R1", rdata, 8'h00);
    check("R1", req, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    check("R1", rdata, 8'h00);
    check("R1", req, 0);
  endtask

  task automatic t_readback;     // R2
    write_ctl(8'b1011_1101);
    check("R2", rdata, 8'b1010_0101);
    write_ctl(8'h00);
    check("R2", rdata, 8'h00);
  endtask

  task automatic t_codes;        // R3
    for (int c = 0; c < 8; c++) begin
      write_ctl({5'b10000, 3'(c)});
      expect_req_at("R3", period_of(3'(c)));
      write_ctl(8'h00);
    end
  endtask

  task automatic t_repeat;       // R4
    int t = period_of(3'b010);
    write_ctl(8'b1000_0010);
    expect_req_at("R4", t);
    expect_req_at("R4", t - 1);
    write_ctl(8'h00);
  endtask

  task automatic t_clear;        // R5
    int t = period_of(3'b000);
    write_ctl(8'b1000_0000);
    step(100);
    write_ctl(8'b1100_0000);
    check("R5", rdata[6], 1);
    step(1);
    check("R5", rdata[6], 0);
    check("R5", req, 0);
    expect_req_at("R5", t);
    write_ctl(8'h00);
  endtask

  task automatic t_idle;         // R6
    int t = period_of(3'b000);
    int p0;
    idle = 1'b1;
    write_ctl(8'b1000_0000);
    p0 = pulses;
    step(299);
    check("R6", pulses - p0, 0);
    idle = 1'b0;
    expect_req_at("R6", t);
    write_ctl(8'h00);
    idle = 1'b1;
    write_ctl(8'b1010_0000);
    expect_req_at("R6", t);
    idle = 1'b0;
    write_ctl(8'h00);
  endtask

  task automatic t_disable;      // R7
    int t = period_of(3'b000);
    int p0;
    write_ctl(8'b1000_0000);
    step(100);
    write_ctl(8'h00);
    p0 = pulses;
    step(600);
    check("R7", pulses - p0, 0);
    write_ctl(8'b1000_0000);
    expect_req_at("R7", t);
    write_ctl(8'h00);
  endtask

  task automatic t_reset_mid;    // R8
    int t = period_of(3'b001);
    write_ctl(8'b1010_0001);
    step(500);
    rst_n = 1'b0;
    step(2);
    check("R8", rdata, 8'h00);
    check("R8", req, 0);
    rst_n = 1'b1;
    write_ctl(8'b1000_0001);
    expect_req_at("R8", t);
    write_ctl(8'h00);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(2);
    t_reset();
    t_readback();
    t_codes();
    t_repeat();
    t_clear();
    t_idle();
    t_disable();
    t_reset_mid();
    finish_run();
  end
endmodule